// File: doc/BRIEF.md
# Configurable GPIO Controller with Sigma-Delta Output

This block controls a bank of general-purpose pins through a small register port. For each pin, software chooses whether the pull-up or pull-down is on and how the output driver behaves. The driver can be push-pull, or open-drain, where the pad is only pulled low. The value driven comes either from a software register or from a shared first-order sigma-delta generator. The generator's output has a density of duty/256.

Pad inputs pass through two synchronizing flops. Software can read them back. They can also raise a CPU interrupt and a wakeup request. Each pin's interrupt fires on a high level or on a chosen edge, and edge events are kept in sticky status bits that are cleared by writing 1. The wakeup request is a separate level match with a per-pin polarity, and it does not depend on the interrupt enables. A global hold control freezes the pad output and enable state ahead of power-down, and a second control forces every output enable low.

Writes take effect on the clock edge where `reg_we` is high. Reads are combinational from `reg_addr`. Pad output and enable come from registers, so a register write reaches the pads one cycle after it lands.

Top module: `pinctl_top`

## Requirements
- R1: After reset, every pad output enable, pull control, `irq` and `wake` is 0, and all registers read 0.
- R2: With push-pull (ODM, address 0x2, bit 0) and register source (SRC, address 0x3, bit 0), `pad_out[i]` equals OUT (address 0x0) bit i and `pad_oe[i]` equals OEN (address 0x1) bit i. Both take effect on the second clock edge after the write.
- R3: In open-drain mode (ODM bit 1), `pad_out[i]` is 0, and `pad_oe[i]` is high only while OEN bit i is 1 and the selected value is 0.
- R4: `pad_pu` follows PUP (address 0x4) and `pad_pd` follows PDN (address 0x5) from the cycle after the write.
- R5: INP (address 0x6) reads the pad inputs delayed by two synchronizer flops. Reads of addresses 0xE and 0xF return 0.
- R6: The trigger field TMD (address 0x8) holds bits [2i+1:2i] for pin i. Codes 01, 10 and 11 select rising, falling and both edges. An edge on an enabled pin (IEN, address 0x7) sets sticky bit i of IST (address 0x9). The bit stays set until 1 is written to it, and `irq` is high while any such bit is set.
- R7: Trigger code 00 selects level mode. `irq` is high while an enabled pin's synchronized input is 1, IST bit i shows that level, and writing 1 to it has no effect.
- R8: `wake` is high while any pin with WEN (address 0xA) bit set has a synchronized input equal to its WPL (address 0xB) bit. This holds whatever the interrupt enables are.
- R9: With SRC bit i set, pin i drives the carry of an 8-bit accumulator that adds SDD (address 0xC, bits 7:0) every cycle. Over any 256 consecutive cycles, the pin is 1 in exactly SDD cycles.
- R10: While HLD (address 0xD) bit 0 is 1, `pad_out` and the registered enables keep their values even when registers change. Clearing the bit brings in the current settings.
- R11: While HLD bit 1 is 1, every `pad_oe` is 0 and `pad_out` keeps following the settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 2*NPIN | Write data |
| reg_rdata | output | 2*NPIN | Read data for `reg_addr` |
| pad_in | input | NPIN | Pad input levels |
| pad_out | output | NPIN | Pad output levels |
| pad_oe | output | NPIN | Pad output enables |
| pad_pu | output | NPIN | Pull-up enables |
| pad_pd | output | NPIN | Pull-down enables |
| irq | output | 1 | CPU interrupt request |
| wake | output | 1 | Wakeup request |

## Verification
The bench builds the block at its defaults: 16 pins, which makes the data path 32 bits wide, and an 8-bit accumulator. With 16 pins, the full trigger field is in use, so each pin's two-bit code lands in its own slice of the bus word. With an 8-bit accumulator, a single window of 256 cycles is enough to count the exact pulse density at duties 0, 64 and 255. The open-drain vectors mix push-pull and open-drain pins in the same word, which shows per-bit selection of the enable logic.

// File: rtl/pinctl_pkg.sv
// Shared register addresses and trigger codes for the pin controller.
package pinctl_pkg;
    typedef enum logic [3:0] {
        ADR_OUT = 4'h0, ADR_OEN = 4'h1, ADR_ODM = 4'h2, ADR_SRC = 4'h3,
        ADR_PUP = 4'h4, ADR_PDN = 4'h5, ADR_INP = 4'h6, ADR_IEN = 4'h7,
        ADR_TMD = 4'h8, ADR_IST = 4'h9, ADR_WEN = 4'hA, ADR_WPL = 4'hB,
        ADR_SDD = 4'hC, ADR_HLD = 4'hD
    } reg_addr_e;

    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'b00, TRIG_RISE = 2'b01, TRIG_FALL = 2'b10, TRIG_BOTH = 2'b11
    } trig_e;
endpackage

// File: rtl/pinctl_regs.sv
// Register file of the pin controller.
// Holds all configuration, decodes writes, produces the W1C clear mask
// for the interrupt status, and serves combinational reads.
// Assumes SDW <= DW and NPIN <= DW.
module pinctl_regs
    import pinctl_pkg::*;
#(
    parameter int NPIN = 16,
    parameter int SDW  = 8,
    parameter int DW   = 2 * NPIN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [3:0]      addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    input  logic [NPIN-1:0] in_sync,
    input  logic [NPIN-1:0] stat_view,
    output logic [NPIN-1:0] out_val,
    output logic [NPIN-1:0] oe_en,
    output logic [NPIN-1:0] od_mode,
    output logic [NPIN-1:0] src_sd,
    output logic [NPIN-1:0] pull_up,
    output logic [NPIN-1:0] pull_dn,
    output logic [NPIN-1:0] irq_en,
    output logic [DW-1:0]   trig_mode,
    output logic [NPIN-1:0] wake_en,
    output logic [NPIN-1:0] wake_pol,
    output logic [SDW-1:0]  sd_duty,
    output logic            hold_freeze,
    output logic            hold_oeoff,
    output logic [NPIN-1:0] stat_clr
);

    // Configuration registers, written by address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_val     <= '0;
            oe_en       <= '0;
            od_mode     <= '0;
            src_sd      <= '0;
            pull_up     <= '0;
            pull_dn     <= '0;
            irq_en      <= '0;
            trig_mode   <= '0;
            wake_en     <= '0;
            wake_pol    <= '0;
            sd_duty     <= '0;
            hold_freeze <= 1'b0;
            hold_oeoff  <= 1'b0;
        end else if (we) begin
            case (addr)
                ADR_OUT: out_val   <= wdata[NPIN-1:0];
                ADR_OEN: oe_en     <= wdata[NPIN-1:0];
                ADR_ODM: od_mode   <= wdata[NPIN-1:0];
                ADR_SRC: src_sd    <= wdata[NPIN-1:0];
                ADR_PUP: pull_up   <= wdata[NPIN-1:0];
                ADR_PDN: pull_dn   <= wdata[NPIN-1:0];
                ADR_IEN: irq_en    <= wdata[NPIN-1:0];
                ADR_TMD: trig_mode <= wdata;
                ADR_WEN: wake_en   <= wdata[NPIN-1:0];
                ADR_WPL: wake_pol  <= wdata[NPIN-1:0];
                ADR_SDD: sd_duty   <= wdata[SDW-1:0];
                ADR_HLD: begin
                    hold_freeze <= wdata[0];
                    hold_oeoff  <= wdata[1];
                end
                default: ;
            endcase
        end
    end

    // Write-one-to-clear mask for the status register.
    always_comb begin
        stat_clr = '0;
        if (we && addr == ADR_IST) stat_clr = wdata[NPIN-1:0];
    end

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        rdata = '0;
        case (addr)
            ADR_OUT: rdata[NPIN-1:0] = out_val;
            ADR_OEN: rdata[NPIN-1:0] = oe_en;
            ADR_ODM: rdata[NPIN-1:0] = od_mode;
            ADR_SRC: rdata[NPIN-1:0] = src_sd;
            ADR_PUP: rdata[NPIN-1:0] = pull_up;
            ADR_PDN: rdata[NPIN-1:0] = pull_dn;
            ADR_INP: rdata[NPIN-1:0] = in_sync;
            ADR_IEN: rdata[NPIN-1:0] = irq_en;
            ADR_TMD: rdata           = trig_mode;
            ADR_IST: rdata[NPIN-1:0] = stat_view;
            ADR_WEN: rdata[NPIN-1:0] = wake_en;
            ADR_WPL: rdata[NPIN-1:0] = wake_pol;
            ADR_SDD: rdata[SDW-1:0]  = sd_duty;
            ADR_HLD: rdata[1:0]      = {hold_oeoff, hold_freeze};
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/pinctl_irq.sv
// Input path of the pin controller.
// Runs each pad through a two-flop synchronizer and a history flop, keeps
// sticky edge status per pin, and forms the interrupt and wakeup requests.
// Assumes pad_in may change at any time relative to clk.
module pinctl_irq
    import pinctl_pkg::*;
#(
    parameter int NPIN = 16,
    parameter int DW   = 2 * NPIN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pad_in,
    input  logic [NPIN-1:0] irq_en,
    input  logic [DW-1:0]   trig_mode,
    input  logic [NPIN-1:0] wake_en,
    input  logic [NPIN-1:0] wake_pol,
    input  logic [NPIN-1:0] stat_clr,
    output logic [NPIN-1:0] in_sync,
    output logic [NPIN-1:0] stat_view,
    output logic            irq,
    output logic            wake
);

    logic [NPIN-1:0] sync1, hist, stat_q, hit;

    // Synchronizer chain plus history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1   <= '0;
            in_sync <= '0;
            hist    <= '0;
        end else begin
            sync1   <= pad_in;
            in_sync <= sync1;
            hist    <= in_sync;
        end
    end

    // Per-pin trigger decode into edge hits and the visible status.
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic [1:0] mode;
        logic       rise, fall;
        assign mode = trig_mode[2*i +: 2];
        assign rise = in_sync[i] & ~hist[i];
        assign fall = ~in_sync[i] & hist[i];
        assign hit[i] = irq_en[i] &
                        (((mode == TRIG_RISE) & rise) |
                         ((mode == TRIG_FALL) & fall) |
                         ((mode == TRIG_BOTH) & (rise | fall)));
        assign stat_view[i] = (mode == TRIG_LEVEL) ? (irq_en[i] & in_sync[i]) : stat_q[i];
    end

    // Sticky edge status: a new hit wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~stat_clr) | hit;
    end

    // Request outputs.
    always_comb begin
        irq  = |stat_view;
        wake = |(wake_en & ~(in_sync ^ wake_pol));
    end

    // R6: a status bit drops only when cleared by software.
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(stat_q) & ~$past(stat_clr)) & ~stat_q) == '0));

    // R5: the readable value is the first stage delayed by one cycle.
    assert_sync_depth_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (in_sync == $past(sync1)));

endmodule

// File: rtl/pinctl_sdm.sv
// First-order sigma-delta generator shared by all pins.
// An SDW-bit accumulator adds the duty word each cycle; its registered
// carry is the density output, duty / 2**SDW.
module pinctl_sdm #(
    parameter int SDW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [SDW-1:0] duty,
    output logic           sd_bit
);

    logic [SDW-1:0] acc;
    logic [SDW:0]   sum;

    // Accumulator sum with carry.
    always_comb sum = {1'b0, acc} + {1'b0, duty};

    // Accumulator and carry register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            sd_bit <= 1'b0;
        end else begin
            acc    <= sum[SDW-1:0];
            sd_bit <= sum[SDW];
        end
    end

    // R9: a zero duty held for two cycles never produces a pulse.
    assert_zero_duty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (duty == '0) |=> !sd_bit);

endmodule

// File: rtl/pinctl_padout.sv
// Pad driver stage. Selects each pin's value, applies push-pull or
// open-drain enables, registers the result and supports hold and
// forced-off enables. Assumes hold is only used around power-down.
module pinctl_padout #(
    parameter int NPIN = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] out_val,
    input  logic [NPIN-1:0] oe_en,
    input  logic [NPIN-1:0] od_mode,
    input  logic [NPIN-1:0] src_sd,
    input  logic            sd_bit,
    input  logic            hold_freeze,
    input  logic            hold_oeoff,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe
);

    logic [NPIN-1:0] drv_val, nxt_out, nxt_oe, out_q, oe_q;

    // Value source and driver-mode mapping.
    always_comb begin
        drv_val = (src_sd & {NPIN{sd_bit}}) | (~src_sd & out_val);
        nxt_out = drv_val & ~od_mode;
        nxt_oe  = oe_en & (~od_mode | ~drv_val);
    end

    // Pad state registers, frozen while hold is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
            oe_q  <= '0;
        end else if (!hold_freeze) begin
            out_q <= nxt_out;
            oe_q  <= nxt_oe;
        end
    end

    // Outputs with the global enable kill.
    always_comb begin
        pad_out = out_q;
        pad_oe  = hold_oeoff ? '0 : oe_q;
    end

    // R10: hold keeps the pad registers unchanged.
    assert_hold_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hold_freeze |=> ($stable(out_q) && $stable(oe_q)));

    // R3: an open-drain pin never presents a high output.
    assert_od_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_freeze |=> ((out_q & $past(od_mode)) == '0));

endmodule

// File: rtl/pinctl_top.sv
// Top of the configurable pin controller: register file, input and
// interrupt path, sigma-delta generator and pad driver stage.
module pinctl_top #(
    parameter int NPIN = 16,
    parameter int SDW  = 8,
    localparam int DW  = 2 * NPIN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [3:0]      reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe,
    output logic [NPIN-1:0] pad_pu,
    output logic [NPIN-1:0] pad_pd,
    output logic            irq,
    output logic            wake
);

    logic [NPIN-1:0] in_sync, stat_view, out_val, oe_en, od_mode, src_sd;
    logic [NPIN-1:0] irq_en, wake_en, wake_pol, stat_clr;
    logic [DW-1:0]   trig_mode;
    logic [SDW-1:0]  sd_duty;
    logic            hold_freeze, hold_oeoff, sd_bit;

    pinctl_regs #(.NPIN(NPIN), .SDW(SDW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .in_sync(in_sync),
        .stat_view(stat_view), .out_val(out_val), .oe_en(oe_en),
        .od_mode(od_mode), .src_sd(src_sd), .pull_up(pad_pu),
        .pull_dn(pad_pd), .irq_en(irq_en), .trig_mode(trig_mode),
        .wake_en(wake_en), .wake_pol(wake_pol), .sd_duty(sd_duty),
        .hold_freeze(hold_freeze), .hold_oeoff(hold_oeoff),
        .stat_clr(stat_clr)
    );

    pinctl_irq #(.NPIN(NPIN), .DW(DW)) u_irq (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .irq_en(irq_en),
        .trig_mode(trig_mode), .wake_en(wake_en), .wake_pol(wake_pol),
        .stat_clr(stat_clr), .in_sync(in_sync), .stat_view(stat_view),
        .irq(irq), .wake(wake)
    );

    pinctl_sdm #(.SDW(SDW)) u_sdm (
        .clk(clk), .rst_n(rst_n), .duty(sd_duty), .sd_bit(sd_bit)
    );

    pinctl_padout #(.NPIN(NPIN)) u_pad (
        .clk(clk), .rst_n(rst_n), .out_val(out_val), .oe_en(oe_en),
        .od_mode(od_mode), .src_sd(src_sd), .sd_bit(sd_bit),
        .hold_freeze(hold_freeze), .hold_oeoff(hold_oeoff),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // R11: the enable kill leaves no pad driven one cycle on.
    assert_oe_kill_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hold_oeoff |=> (pad_oe == '0 || !hold_oeoff));

endmodule

// File: tb/sim_pinctl_top.sv
`timescale 1ns/1ps
module sim_pinctl_top;
    localparam int NPIN = 16;
    localparam int DW   = 32;
    localparam logic [3:0] A_OUT = 4'h0, A_OEN = 4'h1, A_ODM = 4'h2, A_SRC = 4'h3,
                           A_PUP = 4'h4, A_PDN = 4'h5, A_INP = 4'h6, A_IEN = 4'h7,
                           A_TMD = 4'h8, A_IST = 4'h9, A_WEN = 4'hA, A_WPL = 4'hB,
                           A_SDD = 4'hC, A_HLD = 4'hD;

    // {addr, wdata, expected pad_out, expected pad_oe}; R2/R3 vectors
    localparam logic [67:0] VEC [8] = '{
        {A_OUT, 32'h0000A5A5, 16'hA5A5, 16'h0000},
        {A_OEN, 32'h000000FF, 16'hA5A5, 16'h00FF},
        {A_ODM, 32'h00000F0F, 16'hA0A0, 16'h00FA},
        {A_OUT, 32'h0000FFFF, 16'hF0F0, 16'h00F0},
        {A_OEN, 32'h0000FFFF, 16'hF0F0, 16'hF0F0},
        {A_OUT, 32'h00000000, 16'h0000, 16'hFFFF},
        {A_ODM, 32'h00000000, 16'h0000, 16'hFFFF},
        {A_OUT, 32'h00001234, 16'h1234, 16'hFFFF}
    };

    logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0, reg_rdata;
    logic [NPIN-1:0] pad_in = '0, pad_out, pad_oe, pad_pu, pad_pd;
    logic irq, wake;
    int nchk = 0, nerr = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pinctl_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
        .irq(irq), .wake(wake)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_sd(input int duty, input string tag);
        int ones = 0;
        wr(A_SDD, duty);
        waitc(4);
        for (int k = 0; k < 256; k++) begin
            @(negedge clk);
            if (pad_out[0]) ones++;
        end
        chk(tag, ones, duty);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        waitc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pad_oe", pad_oe, 0);
        chk("R1 pulls", {pad_pu, pad_pd}, 0);
        chk("R1 irq/wake", {irq, wake}, 0);
        rd(A_OEN, d); chk("R1 OEN reads 0", d, 0);

        // R2/R3 vector table
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][67:64], VEC[i][63:32]);
            waitc(2);
            chk($sformatf("R2/R3 vec%0d pad_out", i), pad_out, VEC[i][31:16]);
            chk($sformatf("R2/R3 vec%0d pad_oe", i), pad_oe, VEC[i][15:0]);
        end

        // R4 pulls
        wr(A_PUP, 32'h00F0); wr(A_PDN, 32'h0F00);
        chk("R4 pad_pu", pad_pu, 16'h00F0);
        chk("R4 pad_pd", pad_pd, 16'h0F00);

        // R5 input readback and unmapped reads
        pad_in = 16'h3C3C; waitc(4);
        rd(A_INP, d); chk("R5 INP", d, 32'h3C3C);
        rd(4'hE, d); chk("R5 unmapped E", d, 0);
        rd(4'hF, d); chk("R5 unmapped F", d, 0);
        pad_in = 16'h0000; waitc(4);

        // R6 rising edge on pin0
        wr(A_TMD, 32'h1); wr(A_IEN, 32'h1);
        pad_in[0] = 1'b1; waitc(4);
        chk("R6 rise irq", irq, 1);
        rd(A_IST, d); chk("R6 IST bit0", d, 1);
        pad_in[0] = 1'b0; waitc(4);
        chk("R6 sticky", irq, 1);
        wr(A_IST, 32'h1); waitc(1);
        chk("R6 W1C", irq, 0);
        // falling
        wr(A_TMD, 32'h2);
        pad_in[0] = 1'b1; waitc(4);
        chk("R6 fall mode ignores rise", irq, 0);
        pad_in[0] = 1'b0; waitc(4);
        chk("R6 fall irq", irq, 1);
        wr(A_IST, 32'h1);
        // both
        wr(A_TMD, 32'h3);
        pad_in[0] = 1'b1; waitc(4);
        chk("R6 both rise", irq, 1);
        wr(A_IST, 32'h1); waitc(1);
        chk("R6 both cleared", irq, 0);
        pad_in[0] = 1'b0; waitc(4);
        chk("R6 both fall", irq, 1);
        wr(A_IST, 32'h1); waitc(1);

        // R7 level mode on pin1
        wr(A_IEN, 32'h3);
        pad_in[1] = 1'b1; waitc(3);
        chk("R7 level irq", irq, 1);
        rd(A_IST, d); chk("R7 IST shows level", d, 32'h2);
        wr(A_IST, 32'h2); waitc(1);
        chk("R7 W1C no effect", irq, 1);
        pad_in[1] = 1'b0; waitc(3);
        chk("R7 level drop", irq, 0);

        // R8 wake on pin2
        wr(A_WEN, 32'h4); wr(A_WPL, 32'h4);
        pad_in[2] = 1'b1; waitc(3);
        chk("R8 wake high", wake, 1);
        chk("R8 irq unaffected", irq, 0);
        pad_in[2] = 1'b0; waitc(3);
        chk("R8 wake drop", wake, 0);
        wr(A_WPL, 32'h0); waitc(1);
        chk("R8 wake low polarity", wake, 1);
        wr(A_WEN, 32'h0); waitc(1);
        chk("R8 wake disabled", wake, 0);

        // R9 sigma-delta density on pin0
        wr(A_SRC, 32'h1);
        count_sd(64, "R9 duty 64");
        count_sd(0, "R9 duty 0");
        count_sd(255, "R9 duty 255");
        wr(A_SRC, 32'h0);

        // R10 hold
        wr(A_OUT, 32'h00FF); waitc(2);
        chk("R10 before hold", pad_out, 16'h00FF);
        wr(A_HLD, 32'h1);
        wr(A_OUT, 32'hFF00); waitc(3);
        chk("R10 held", pad_out, 16'h00FF);
        wr(A_HLD, 32'h0); waitc(2);
        chk("R10 released", pad_out, 16'hFF00);

        // R11 enable kill
        wr(A_HLD, 32'h2); waitc(1);
        chk("R11 oe forced low", pad_oe, 16'h0000);
        wr(A_OUT, 32'h0F0F); waitc(2);
        chk("R11 out follows", pad_out, 16'h0F0F);
        wr(A_HLD, 32'h0); waitc(1);
        chk("R11 oe restored", pad_oe, 16'hFFFF);

        finish_run();
    end
endmodule